// File: doc/BRIEF.md
# Reset Request Arbiter with Reset Classes

This block collects reset requests from seven sources and sorts each one into one of three reset classes. The power-on request is the cold class. It drives the cold reset output and wipes all state in the block. The two external system request lines, the watchdog, software and debug requests are the warm class. They share one system warm reset output, which pulses for a fixed number of cycles. The JTAG request is the special class. It drives its own debug-domain reset pulse and leaves the system warm reset alone.

Every request also sets a sticky bit in a cause register, so code that runs after a warm reset can see why the reset happened. Only a cold reset clears that register. The block counts warm resets that were caused by the watchdog alone and that follow one another with no other reset between them. When that count reaches its limit, which is two by default, the warm reset output is held asserted until power-on reset is applied again.

All inputs are synchronous to `clk`. `por_req` also works as the synchronous clear of the block's own state.

Top module: `rstreq_arbiter`

## Requirements
- R1: `cold_rst_o` equals the value `por_req` had at the previous rising clock edge.
- R2: Each warm request, sampled at an edge while no warm pulse is running, raises `warm_rst_o` after that edge. The output then stays high for exactly `PULSE_CYCLES` cycles (16 by default). The warm requests are `esr_req[0]`, `esr_req[1]`, `wdt_req`, `sw_req` and `dbg_req`.
- R3: A warm request that arrives while a warm pulse is running is merged into that pulse. It neither lengthens nor restarts the pulse, but it still sets its cause bit.
- R4: `jtag_req` produces a `spec_rst_o` pulse of `PULSE_CYCLES` cycles, timed the same way as in R2. A JTAG request on its own never asserts `warm_rst_o`.
- R5: The cause register bit positions are: bit 0 power-on, bit 1 `esr_req[0]`, bit 2 `esr_req[1]`, bit 3 watchdog, bit 4 software, bit 5 debug, bit 6 JTAG. Bits 1 to 6 are sticky and are set by their request. A power-on request sets the register to exactly 1 (bit 0 only).
- R6: A watchdog-only warm pulse start is one where `wdt_req` is the only request high in the start cycle. After `LOCK_COUNT` such starts in a row (2 by default), `warm_rst_o` stays high until `por_req`.
- R7: Any warm pulse start that is not watchdog-only, and any special pulse start, resets the consecutive-watchdog count to zero.
- R8: A start cycle in which `wdt_req` is high together with any other request does not count as watchdog-only.
- R9: While `por_req` is applied, the next cycle shows `warm_rst_o` and `spec_rst_o` low. Running pulses and the lock are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on (cold) reset request, active high |
| esr_req | input | 2 | External system reset requests, active high |
| wdt_req | input | 1 | Watchdog reset request |
| sw_req | input | 1 | Software reset request |
| dbg_req | input | 1 | Debug reset request |
| jtag_req | input | 1 | JTAG special reset request |
| cold_rst_o | output | 1 | Cold reset output |
| warm_rst_o | output | 1 | System warm reset output |
| spec_rst_o | output | 1 | Debug-domain special reset output |
| cause_o | output | 7 | Sticky reset cause bits (see R5) |

## Verification
The assertions assume that all request inputs are synchronous to `clk`. They also assume that `por_req` is applied before the first checked cycle, because the sticky-cause and countdown properties compare against a state that a cold reset has set up.

The bench applies a cold reset at the start of every scenario. It changes requests only on falling edges and holds each request for one clock cycle, so every request is seen at exactly one rising edge. It waits out each pulse before sending the next request, except where the aim is to test merging into a running pulse.

// File: rtl/rstarb_pkg.sv
package rstarb_pkg;
    localparam int unsigned NUM_SRC   = 7;
    localparam int unsigned SRC_POR   = 0;
    localparam int unsigned SRC_ESR0  = 1;
    localparam int unsigned SRC_ESR1  = 2;
    localparam int unsigned SRC_WDT   = 3;
    localparam int unsigned SRC_SW    = 4;
    localparam int unsigned SRC_DBG   = 5;
    localparam int unsigned SRC_JTAG  = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Reset class of each source; JTAG is the only special one.
    typedef enum logic [1:0] {
        CLS_COLD    = 2'd0,
        CLS_WARM    = 2'd1,
        CLS_SPECIAL = 2'd2
    } rst_class_e;

    function automatic rst_class_e class_of(input int unsigned src);
        if (src == SRC_POR)  return CLS_COLD;
        if (src == SRC_JTAG) return CLS_SPECIAL;
        return CLS_WARM;
    endfunction
endpackage

// File: rtl/rstarb_pulse.sv
module rstarb_pulse #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic trig,
    output logic start_o,
    output logic active_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = trig && (st_q.cnt == '0) && !clr;
        if (clr) begin
            st_d.cnt = '0;
        end else if (start_o) begin
            st_d.cnt = CW'(LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);

    // R2: a pulse that is running counts down one step per cycle and is never reloaded
    a_r2_countdown: assert property (@(posedge clk) disable iff (clr)
        (st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R2: a request seen while idle loads the full length
    a_r2_idle_load: assert property (@(posedge clk) disable iff (clr)
        ((st_q.cnt == '0) && trig) |=> (st_q.cnt == CW'(LEN)));
endmodule

// File: rtl/rstarb_wdt_lock.sv
module rstarb_wdt_lock #(
    parameter int unsigned LOCK_COUNT = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic warm_start,
    input  logic wdt_only,
    input  logic spec_start,
    output logic lock_o
);
    localparam int unsigned CW = $clog2(LOCK_COUNT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lock;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.lock = 1'b0;
        end else if (warm_start && wdt_only) begin
            if (st_q.cnt < CW'(LOCK_COUNT)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt >= CW'(LOCK_COUNT - 1)) begin
                st_d.lock = 1'b1;
            end
        end else if (warm_start || spec_start) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    // R6: once set, the lock stays set until a cold reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (clr)
        lock_o |=> lock_o);

    // R7: a reset that is not watchdog-only clears the repeat count
    a_r7_count_cleared: assert property (@(posedge clk) disable iff (clr)
        ((warm_start && !wdt_only) || (spec_start && !warm_start)) |=> (st_q.cnt == '0));
endmodule

// File: rtl/rstreq_arbiter.sv
module rstreq_arbiter
    import rstarb_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 16,
    parameter int unsigned LOCK_COUNT   = 2
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic [1:0] esr_req,
    input  logic       wdt_req,
    input  logic       sw_req,
    input  logic       dbg_req,
    input  logic       jtag_req,
    output logic       cold_rst_o,
    output logic       warm_rst_o,
    output logic       spec_rst_o,
    output logic [6:0] cause_o
);
    typedef struct packed {
        logic     cold;
        src_vec_t cause;
    } top_st_t;

    top_st_t  st_d, st_q;
    src_vec_t req_vec;
    src_vec_t warm_mask;
    src_vec_t spec_mask;
    logic     warm_any, spec_any, wdt_only;
    logic     warm_start, warm_active, spec_start, spec_active, lock;

    always_comb begin
        req_vec            = '0;
        req_vec[SRC_POR]   = por_req;
        req_vec[SRC_ESR0]  = esr_req[0];
        req_vec[SRC_ESR1]  = esr_req[1];
        req_vec[SRC_WDT]   = wdt_req;
        req_vec[SRC_SW]    = sw_req;
        req_vec[SRC_DBG]   = dbg_req;
        req_vec[SRC_JTAG]  = jtag_req;
    end

    // Class masks derived from the source-to-class mapping
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
        assign warm_mask[g] = (class_of(g) == CLS_WARM);
        assign spec_mask[g] = (class_of(g) == CLS_SPECIAL);
    end

    assign warm_any = |(req_vec & warm_mask);
    assign spec_any = |(req_vec & spec_mask);
    assign wdt_only = (req_vec == (src_vec_t'(1) << SRC_WDT));

    always_comb begin
        st_d      = st_q;
        st_d.cold = por_req;
        if (por_req) begin
            st_d.cause = src_vec_t'(1) << SRC_POR;
        end else begin
            st_d.cause = st_q.cause | req_vec;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    rstarb_pulse #(.LEN(PULSE_CYCLES)) u_warm_pulse (
        .clk      (clk),
        .clr      (por_req),
        .trig     (warm_any),
        .start_o  (warm_start),
        .active_o (warm_active)
    );

    rstarb_pulse #(.LEN(PULSE_CYCLES)) u_spec_pulse (
        .clk      (clk),
        .clr      (por_req),
        .trig     (spec_any),
        .start_o  (spec_start),
        .active_o (spec_active)
    );

    rstarb_wdt_lock #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk        (clk),
        .clr        (por_req),
        .warm_start (warm_start),
        .wdt_only   (wdt_only),
        .spec_start (spec_start),
        .lock_o     (lock)
    );

    assign cold_rst_o = st_q.cold;
    assign warm_rst_o = warm_active | lock;
    assign spec_rst_o = spec_active;
    assign cause_o    = st_q.cause;

    // R9: a cold request silences both pulse outputs and resets the cause
    a_r9_cold_quiets: assert property (@(posedge clk)
        por_req |=> (!warm_rst_o && !spec_rst_o && cause_o == 7'd1));

    // R5: cause bits never fall without a cold reset
    a_r5_cause_sticky: assert property (@(posedge clk) disable iff (por_req)
        1'b1 |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    // R4: JTAG alone never starts the system warm reset
    a_r4_jtag_isolated: assert property (@(posedge clk) disable iff (por_req)
        (!warm_rst_o && jtag_req && !warm_any) |=> !warm_rst_o);

    // R6: while locked the warm reset output stays high
    a_r6_locked_warm: assert property (@(posedge clk) disable iff (por_req)
        lock |=> warm_rst_o);
endmodule

// File: tb/rstreq_arbiter_test.sv
module rstreq_arbiter_test;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic [1:0] esr_req = '0;
    logic       wdt_req = 1'b0, sw_req = 1'b0, dbg_req = 1'b0, jtag_req = 1'b0;
    logic       cold_rst_o, warm_rst_o, spec_rst_o;
    logic [6:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstreq_arbiter uut (
        .clk(clk), .por_req(por_req), .esr_req(esr_req), .wdt_req(wdt_req),
        .sw_req(sw_req), .dbg_req(dbg_req), .jtag_req(jtag_req),
        .cold_rst_o(cold_rst_o), .warm_rst_o(warm_rst_o),
        .spec_rst_o(spec_rst_o), .cause_o(cause_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] m);
        esr_req  = m[1:0];
        wdt_req  = m[2];
        sw_req   = m[3];
        dbg_req  = m[4];
        jtag_req = m[5];
    endtask

    // Cold reset with R1/R9 checks
    task automatic do_por();
        @(negedge clk);
        por_req = 1'b1;
        drive(6'd0);
        @(negedge clk);
        chk("R1 cold high", int'(cold_rst_o), 1);
        chk("R9 warm low in cold", int'(warm_rst_o), 0);
        chk("R9 spec low in cold", int'(spec_rst_o), 0);
        chk("R5 cause after cold", int'(cause_o), 1);
        por_req = 1'b0;
        @(negedge clk);
        chk("R1 cold released", int'(cold_rst_o), 0);
    endtask

    // One-cycle request, then count output-high cycles over 20 samples
    task automatic fire(input logic [5:0] m, output int wc, output int sc, output int wfirst);
        @(negedge clk);
        drive(m);
        @(negedge clk);
        drive(6'd0);
        wfirst = int'(warm_rst_o);
        wc = int'(warm_rst_o);
        sc = int'(spec_rst_o);
        for (int i = 1; i < 20; i++) begin
            @(negedge clk);
            wc += int'(warm_rst_o);
            sc += int'(spec_rst_o);
        end
    endtask

    initial begin
        int wc, sc, wf;
        int expw, exps;
        repeat (3) @(negedge clk);
        do_por();

        // R2/R4/R5: sweep every combination of the six non-cold requests
        for (int m = 1; m < 64; m++) begin
            do_por();
            fire(6'(m), wc, sc, wf);
            expw = ((m & 5'h1f) != 0) ? PULSE : 0;
            exps = ((m & 6'h20) != 0) ? PULSE : 0;
            chk("R2 warm pulse length", wc, expw);
            chk("R2 warm starts next cycle", wf, (expw != 0) ? 1 : 0);
            chk("R4 spec pulse length", sc, exps);
            chk("R5 cause bits", int'(cause_o), 1 | (m << 1));
        end

        // R3 merge, then R6 lock
        do_por();
        @(negedge clk); drive(6'b000100);
        @(negedge clk); drive(6'd0);
        wc = int'(warm_rst_o);
        for (int i = 1; i < 20; i++) begin
            @(negedge clk);
            if (i == 5) sw_req = 1'b1;
            if (i == 6) sw_req = 1'b0;
            wc += int'(warm_rst_o);
        end
        chk("R3 merged pulse length", wc, PULSE);
        chk("R3 merged cause", int'(cause_o), 1 | (1 << 3) | (1 << 4));
        fire(6'b000100, wc, sc, wf);
        chk("R6 second wdt locks", wc, 20);
        repeat (50) @(negedge clk);
        chk("R6 lock persists", int'(warm_rst_o), 1);
        fire(6'b001000, wc, sc, wf);
        chk("R6 lock ignores sw", wc, 20);
        do_por();
        chk("R9 cold clears lock", int'(warm_rst_o), 0);

        // R7: software reset between watchdog resets
        fire(6'b000100, wc, sc, wf);
        fire(6'b001000, wc, sc, wf);
        fire(6'b000100, wc, sc, wf);
        chk("R7 sw clears wdt count", wc, PULSE);

        // R7: JTAG reset between watchdog resets
        do_por();
        fire(6'b000100, wc, sc, wf);
        fire(6'b100000, wc, sc, wf);
        chk("R4 jtag no warm", wc, 0);
        fire(6'b000100, wc, sc, wf);
        chk("R7 jtag clears wdt count", wc, PULSE);

        // R8: wdt together with sw is not watchdog-only
        do_por();
        fire(6'b001100, wc, sc, wf);
        fire(6'b000100, wc, sc, wf);
        chk("R8 mixed start not counted", wc, PULSE);
        fire(6'b000100, wc, sc, wf);
        chk("R8 then two wdt lock", wc, 20);

        // R9: cold reset in the middle of a pulse
        do_por();
        @(negedge clk); drive(6'b100001);
        @(negedge clk); drive(6'd0);
        repeat (3) @(negedge clk);
        por_req = 1'b1;
        @(negedge clk);
        chk("R9 warm cut by cold", int'(warm_rst_o), 0);
        chk("R9 spec cut by cold", int'(spec_rst_o), 0);
        por_req = 1'b0;
        @(negedge clk);
        chk("R9 stays quiet after cold", int'(warm_rst_o | spec_rst_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule